// File: doc/BRIEF.md
# Display Refill and Frame-Complete Controller

This block sits between the display FIFOs of a video output path and the DMA engine that fills them. As the timing generator takes active luma samples out of the FIFO, the block counts them in chunks of a fixed threshold. Each field starts with a priming refill request. After that, one request follows each drained chunk until the field's programmed number of requests has been raised. Every request goes out as a simultaneous pulse on a luma channel and two chroma channels. The transfer length of each channel is presented as a constant beside the pulses.

At the last sample of the second field, the block marks the frame as complete. In non-continuous mode the display then stops until software acknowledges the frame. The block also watches for samples taken from an empty FIFO, records them as underruns and substitutes a blanking value. A small register block holds the control bits, the interrupt enables and write-one-to-clear status. An interrupt line combines the enabled status.

Top module: `vd_refill_ctl`

## Requirements
- R1: The threshold is LINE_SAMPLES/8 double-words. `req_y_len` equals twice that in 32-bit words, and `req_c_len` equals the threshold itself (180 and 90 for 720-sample lines).
- R2: Each accepted field start (`fld_start` while running) clears the field's counters. The field raises exactly LINE_SAMPLES*lines/(threshold*8) requests: one at field start, then one per drained threshold of luma bytes except the last (244 for field 0, 243 for field 1 by default). It never raises more.
- R3: `req_y`, `req_cb` and `req_cr` pulse together, one cycle per request.
- R4: While CTRL bit 2 (block) is set, no request pulse is issued. Requests that fall due are held and are issued after the bit clears, with none lost.
- R5: `disp_run` is high only when CTRL bit 0 (enable) is 1, CTRL bit 1 (halt) is 0, and the frame is not waiting for acknowledgement. Consume strobes and field starts arriving while `disp_run` is low change nothing.
- R6: The consume that completes the final threshold of field 1 (`fld_id`=1) sets STAT bit 0 (frame done) and STAT bit 1 (complete interrupt). It does not set them one sample earlier.
- R7: With CTRL bit 3 (continuous) at 0, `disp_run` drops after frame completion and returns only when STAT bit 0 is cleared. With bit 3 at 1, display keeps running.
- R8: A consume accepted while `fifo_empty` is high sets STAT bit 2 (underrun). `pix_out` shows BLANK (0x10) whenever `fifo_empty` is high and shows `pix_in` otherwise.
- R9: Writing 1 to a STAT bit (address 2) clears it, and writing 0 leaves it. A set event in the same cycle wins over the clear.
- R10: `irq` = IE bit 2 (global) AND ((IE bit 0 AND STAT bit 1) OR (IE bit 1 AND STAT bit 2)), where IE is at address 1.
- R11: After reset, CTRL (address 0) reads 0x6 (halt and block set), IE and STAT read 0, and `irq`, `disp_run` and all requests are low. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fld_start | input | 1 | Field start pulse from timing generator |
| fld_id | input | 1 | Field being started (0 first, 1 second) |
| cons | input | 1 | One luma sample consumed this cycle |
| fifo_empty | input | 1 | Luma FIFO is empty |
| pix_in | input | PIX_W | Sample read from the FIFO |
| pix_out | output | PIX_W | Sample to display, blanked on empty |
| disp_run | output | 1 | Display may proceed |
| req_y | output | 1 | Luma refill request pulse |
| req_cb | output | 1 | Blue-difference chroma refill request pulse |
| req_cr | output | 1 | Red-difference chroma refill request pulse |
| req_y_len | output | LEN_W | Luma words per request |
| req_c_len | output | LEN_W | Chroma words per request |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 4 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 4 | Register read data (combinational) |
| irq | output | 1 | Interrupt |

## Verification
The bench goes after the exact request count per field. A counter that primes twice, or that also issues after the final chunk, shows up as one request too many. Frame completion is checked on the exact final sample, so an off-by-one comparison is caught as a done flag that is early or never set. Consume strobes sent while the frame is halted must not move any count and must not record underrun. A design that counts them would complete the next frame early. Withheld requests under the block bit must all reappear. Status acknowledgement is probed with zero writes and partial clears, which exposes a register that clears on any write or that drops the interrupt wrongly.

// File: rtl/vd_pkg.sv
package vd_pkg;
  // threshold in 64-bit double-words for one line of luma bytes
  function automatic int thr_dw(input int line_samples);
    return line_samples / 8;
  endfunction

  // number of threshold-sized requests in one field
  function automatic int field_reqs(input int line_samples, input int lines);
    return (line_samples * lines) / (thr_dw(line_samples) * 8);
  endfunction

  // 32-bit words moved per luma request
  function automatic int luma_words(input int line_samples);
    return thr_dw(line_samples) * 2;
  endfunction

  // register addresses
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_IE   = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  typedef struct packed {
    logic cont;
    logic blk;
    logic halt;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/vd_drain.sv
module vd_drain #(
  parameter int THR_BYTES = 720,
  parameter int N0 = 244,
  parameter int N1 = 243,
  localparam int NMAX = (N0 > N1) ? N0 : N1,
  localparam int CNT_W = $clog2(NMAX + 1),
  localparam int SAMP_W = (THR_BYTES > 1) ? $clog2(THR_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fld_acc,
  input  logic             fld_id,
  input  logic             take,
  output logic             due,
  output logic             frame_end,
  output logic [CNT_W-1:0] cur_lim
);
  logic              fid_q;
  logic [SAMP_W-1:0] samp_q;
  logic [CNT_W-1:0]  chunk_q;
  logic              full, accept, wrap, last_chunk;

  assign cur_lim    = fid_q ? CNT_W'(N1) : CNT_W'(N0);
  assign full       = (chunk_q == cur_lim);
  assign accept     = take && !full && !fld_acc;
  assign wrap       = accept && (samp_q == SAMP_W'(THR_BYTES - 1));
  assign last_chunk = (chunk_q + 1'b1) == cur_lim;
  assign due        = fld_acc || (wrap && !last_chunk);
  assign frame_end  = wrap && last_chunk && fid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fid_q   <= 1'b1;
      samp_q  <= '0;
      chunk_q <= CNT_W'(N1);
    end else if (fld_acc) begin
      fid_q   <= fld_id;
      samp_q  <= '0;
      chunk_q <= '0;
    end else if (accept) begin
      if (wrap) begin
        samp_q  <= '0;
        chunk_q <= chunk_q + 1'b1;
      end else begin
        samp_q <= samp_q + 1'b1;
      end
    end
  end

  // R6: completion only reported for the second field
  p_end_second_field_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (fid_q && (chunk_q == CNT_W'(N1))));
endmodule

// File: rtl/vd_req_issue.sv
module vd_req_issue #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic due,
  input  logic blk,
  output logic req
);
  logic [CNT_W:0] pend_q;
  logic           issue;

  assign issue = !blk && (pend_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      req    <= 1'b0;
    end else begin
      pend_q <= pend_q + (CNT_W+1)'(due) - (CNT_W+1)'(issue);
      req    <= issue;
    end
  end

  // R4: a withheld channel stays quiet
  p_blk_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    blk |=> !req);
  // R4: a due request while unblocked is issued in one of the next cycles
  p_pend_issues_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (due && !blk && pend_q == '0) |=> (blk || req || pend_q != '0));
endmodule

// File: rtl/vd_regs.sv
module vd_regs
  import vd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [3:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [3:0] rd_data,
  input  logic       frame_end,
  input  logic       und_evt,
  output ctrl_t      ctrl,
  output logic       frm_done,
  output logic       cmp_st,
  output logic       und_st,
  output logic       irq
);
  logic [2:0] ie_q;
  logic       w_ctrl, w_ie, w_stat;

  assign w_ctrl = wr_en && (wr_addr == A_CTRL);
  assign w_ie   = wr_en && (wr_addr == A_IE);
  assign w_stat = wr_en && (wr_addr == A_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl     <= '{cont: 1'b0, blk: 1'b1, halt: 1'b1, en: 1'b0};
      ie_q     <= '0;
      frm_done <= 1'b0;
      cmp_st   <= 1'b0;
      und_st   <= 1'b0;
    end else begin
      if (w_ctrl) ctrl <= ctrl_t'(wr_data);
      if (w_ie)   ie_q <= wr_data[2:0];
      frm_done <= frame_end || (frm_done && !(w_stat && wr_data[0]));
      cmp_st   <= frame_end || (cmp_st   && !(w_stat && wr_data[1]));
      und_st   <= und_evt   || (und_st   && !(w_stat && wr_data[2]));
    end
  end

  assign irq = ie_q[2] && ((ie_q[0] && cmp_st) || (ie_q[1] && und_st));

  always_comb begin
    unique case (rd_addr)
      A_CTRL:  rd_data = ctrl;
      A_IE:    rd_data = {1'b0, ie_q};
      A_STAT:  rd_data = {1'b0, und_st, cmp_st, frm_done};
      default: rd_data = '0;
    endcase
  end

  // R9: set event wins over a same-cycle clear
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (frm_done && cmp_st));
  // R9: a zero write does not clear the underrun bit
  p_zero_write_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (und_st && !(w_stat && wr_data[2])) |=> und_st);
  // R10: enabled underrun with global enable raises the line
  p_irq_und_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (und_st && ie_q[1] && ie_q[2]) |-> irq);
endmodule

// File: rtl/vd_refill_ctl.sv
module vd_refill_ctl
  import vd_pkg::*;
#(
  parameter int LINE_SAMPLES = 720,
  parameter int F0_LINES = 244,
  parameter int F1_LINES = 243,
  parameter int PIX_W = 8,
  parameter logic [PIX_W-1:0] BLANK = PIX_W'(8'h10),
  localparam int THR_DW = thr_dw(LINE_SAMPLES),
  localparam int THR_BYTES = THR_DW * 8,
  localparam int N0 = field_reqs(LINE_SAMPLES, F0_LINES),
  localparam int N1 = field_reqs(LINE_SAMPLES, F1_LINES),
  localparam int NMAX = (N0 > N1) ? N0 : N1,
  localparam int CNT_W = $clog2(NMAX + 1),
  localparam int LEN_W = $clog2(luma_words(LINE_SAMPLES) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fld_start,
  input  logic             fld_id,
  input  logic             cons,
  input  logic             fifo_empty,
  input  logic [PIX_W-1:0] pix_in,
  output logic [PIX_W-1:0] pix_out,
  output logic             disp_run,
  output logic             req_y,
  output logic             req_cb,
  output logic             req_cr,
  output logic [LEN_W-1:0] req_y_len,
  output logic [LEN_W-1:0] req_c_len,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [3:0]       wr_data,
  input  logic [1:0]       rd_addr,
  output logic [3:0]       rd_data,
  output logic             irq
);
  localparam int NCH = 3;

  ctrl_t            ctrl;
  logic             frm_done, cmp_st, und_st;
  logic             fld_acc, take, und_evt, due, frame_end;
  logic [CNT_W-1:0] cur_lim;
  logic [NCH-1:0]   req_vec;

  assign disp_run = ctrl.en && !ctrl.halt && !(!ctrl.cont && frm_done);
  assign fld_acc  = fld_start && disp_run;
  assign take     = cons && disp_run;
  assign und_evt  = take && fifo_empty;
  assign pix_out  = fifo_empty ? BLANK : pix_in;

  assign req_y_len = LEN_W'(luma_words(LINE_SAMPLES));
  assign req_c_len = LEN_W'(THR_DW);

  vd_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .frame_end(frame_end), .und_evt(und_evt), .ctrl(ctrl),
    .frm_done(frm_done), .cmp_st(cmp_st), .und_st(und_st), .irq(irq)
  );

  vd_drain #(.THR_BYTES(THR_BYTES), .N0(N0), .N1(N1)) u_drain (
    .clk(clk), .rst_n(rst_n), .fld_acc(fld_acc), .fld_id(fld_id),
    .take(take), .due(due), .frame_end(frame_end), .cur_lim(cur_lim)
  );

  // one issuer per channel: luma, blue chroma, red chroma
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    vd_req_issue #(.CNT_W(CNT_W)) u_iss (
      .clk(clk), .rst_n(rst_n), .due(due), .blk(ctrl.blk), .req(req_vec[c])
    );
  end

  assign req_y  = req_vec[0];
  assign req_cb = req_vec[1];
  assign req_cr = req_vec[2];

  // per-field due counter for the cap check
  logic [CNT_W:0] due_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)       due_cnt <= '0;
    else if (fld_acc) due_cnt <= (CNT_W+1)'(1);
    else if (due)     due_cnt <= due_cnt + 1'b1;
  end

  // R2: never more than the programmed count in a field
  p_field_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (due && !fld_acc) |-> (due_cnt < (CNT_W+1)'(cur_lim)));
  // R3: the three channels move in lockstep
  p_req_lockstep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_y == req_cb) && (req_cb == req_cr));
  // R7: non-continuous mode stops after the frame
  p_halt_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !ctrl.cont) |=> !disp_run);
  // R8: underrun is latched
  p_und_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    und_evt |=> und_st);
endmodule

// File: tb/tb_vd_refill_ctl.sv
module tb_vd_refill_ctl;
  localparam int LINE = 16;
  localparam int L0 = 4;
  localparam int L1 = 3;
  localparam int LEN_W = $clog2((LINE/8)*2 + 1);

  logic clk = 0, rst_n = 0;
  logic fld_start = 0, fld_id = 0, cons = 0, fifo_empty = 0;
  logic [7:0] pix_in = 0, pix_out;
  logic disp_run, req_y, req_cb, req_cr, irq;
  logic [LEN_W-1:0] req_y_len, req_c_len;
  logic wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 2;
  logic [3:0] wr_data = 0, rd_data;

  int nchk = 0, nfail = 0, rq = 0, skew = 0;
  bit any_empty;

  always #2 clk = ~clk;

  vd_refill_ctl #(.LINE_SAMPLES(LINE), .F0_LINES(L0), .F1_LINES(L1)) dut (
    .clk(clk), .rst_n(rst_n), .fld_start(fld_start), .fld_id(fld_id),
    .cons(cons), .fifo_empty(fifo_empty), .pix_in(pix_in), .pix_out(pix_out),
    .disp_run(disp_run), .req_y(req_y), .req_cb(req_cb), .req_cr(req_cr),
    .req_y_len(req_y_len), .req_c_len(req_c_len), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq));

  function automatic int exp_reqs(input int lines);
    return (LINE * lines) / ((LINE / 8) * 8);
  endfunction

  always @(negedge clk) begin
    if (req_y) rq++;
    if (req_y != req_cb || req_y != req_cr) skew++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rreg(input logic [1:0] a, output int v);
    rd_addr = a; #1; v = int'(rd_data);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_field(input bit id);
    @(negedge clk); fld_start = 1; fld_id = id;
    @(negedge clk); fld_start = 0;
  endtask

  // consume n samples with random gaps; empty with probability 1/erate
  task automatic consume(input int n, input int erate, input bit last_watch);
    int v;
    for (int i = 0; i < n; i++) begin
      if (last_watch && i == n - 1) begin
        rreg(2'd2, v);
        chk((v & 1) == 0, "R6 done not early", v & 1, 0);
      end
      cons = 1;
      fifo_empty = (erate > 0) && ($urandom_range(0, erate - 1) == 0);
      pix_in = 8'($urandom_range(0, 255));
      if (fifo_empty) any_empty = 1;
      #1;
      if (fifo_empty) chk(pix_out == 8'h10, "R8 blank", pix_out, 8'h10);
      else if (i % 8 == 0) chk(pix_out == pix_in, "R8 pass", pix_out, pix_in);
      @(negedge clk); cons = 0; fifo_empty = 0;
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end
  endtask

  task automatic run_field(input bit id, input int lines, input int erate, input bit watch);
    int base;
    base = rq;
    start_field(id);
    consume(LINE * lines, erate, watch);
    idle(6);
    chk(rq - base == exp_reqs(lines), id ? "R2 field1 count" : "R2 field0 count",
        rq - base, exp_reqs(lines));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", nchk, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int v, base;
    void'($urandom(32'd4711));
    idle(3); rst_n = 1; idle(2);
    // R11 reset state
    rreg(2'd0, v); chk(v == 6, "R11 ctrl", v, 6);
    rreg(2'd1, v); chk(v == 0, "R11 ie", v, 0);
    rreg(2'd2, v); chk(v == 0, "R11 stat", v, 0);
    rreg(2'd3, v); chk(v == 0, "R11 addr3", v, 0);
    chk(!irq && !disp_run && rq == 0, "R11 outputs", {irq, disp_run}, 0);
    // R1 lengths
    chk(req_y_len == 4, "R1 luma len", req_y_len, 4);
    chk(req_c_len == 2, "R1 chroma len", req_c_len, 2);
    // R5 halted start ignored
    base = rq;
    start_field(0); consume(20, 0, 0); idle(4);
    chk(rq == base, "R5 halted ignored", rq - base, 0);
    wreg(2'd0, 4'b0001);
    chk(disp_run == 1, "R5 run on", disp_run, 1);
    wreg(2'd1, 4'b0111);

    // frame A, non-continuous
    any_empty = 0;
    run_field(0, L0, 0, 0);
    run_field(1, L1, 0, 1);
    rreg(2'd2, v); chk(v == 3, "R6 stat after frame", v, 3);
    chk(!disp_run, "R7 halted after frame", disp_run, 0);
    chk(irq, "R10 irq cmp", irq, 1);
    // R5 consumes while halted: no count, no underrun
    base = rq;
    start_field(0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); cons = 1; fifo_empty = 1;
    end
    @(negedge clk); cons = 0; fifo_empty = 0; idle(4);
    chk(rq == base, "R5 no req while halted", rq - base, 0);
    rreg(2'd2, v); chk(v == 3, "R5 no und while halted", v, 3);
    // R9 acknowledge
    wreg(2'd2, 4'b0000); rreg(2'd2, v); chk(v == 3, "R9 zero write", v, 3);
    wreg(2'd2, 4'b0010); rreg(2'd2, v); chk(v == 1, "R9 partial clear", v, 1);
    chk(!irq, "R10 irq drops", irq, 0);
    chk(!disp_run, "R7 still halted", disp_run, 0);
    wreg(2'd2, 4'b0001);
    chk(disp_run, "R7 resumes", disp_run, 1);

    // frame B with underruns
    any_empty = 0;
    run_field(0, L0, 5, 0);
    run_field(1, L1, 5, 1);
    rreg(2'd2, v);
    chk(v == (any_empty ? 7 : 3), "R8 und status", v, any_empty ? 7 : 3);
    wreg(2'd1, 4'b0110); idle(1);
    chk(irq == any_empty, "R10 und irq", irq, any_empty);
    wreg(2'd2, 4'b0111);

    // frame C with block bit
    wreg(2'd0, 4'b0101);
    base = rq;
    start_field(0); consume(LINE * L0, 0, 0); idle(6);
    chk(rq == base, "R4 withheld", rq - base, 0);
    wreg(2'd0, 4'b0001); idle(12);
    chk(rq - base == exp_reqs(L0), "R4 released", rq - base, exp_reqs(L0));
    run_field(1, L1, 0, 1);
    wreg(2'd2, 4'b0111);

    // R2 restart mid-field resets counters
    base = rq;
    start_field(0); consume(20, 0, 0); idle(5);
    chk(rq - base == 2, "R2 partial", rq - base, 2);
    run_field(0, L0, 0, 0);
    run_field(1, L1, 0, 1);
    wreg(2'd2, 4'b0111);

    // continuous mode, random frames
    wreg(2'd0, 4'b1001);
    wreg(2'd1, 4'b0001);
    for (int f = 0; f < 3; f++) begin
      run_field(0, L0, 7, 0);
      run_field(1, L1, 7, 1);
      chk(disp_run, "R7 continuous runs", disp_run, 1);
      rreg(2'd2, v); chk((v & 3) == 3, "R6 done cont", v & 3, 3);
      chk(!irq, "R10 no global", irq, 0);
      wreg(2'd2, 4'b0111);
    end
    wreg(2'd1, 4'b0101);
    run_field(0, L0, 0, 0);
    run_field(1, L1, 0, 1);
    chk(irq, "R10 global on", irq, 1);
    chk(skew == 0, "R3 lockstep", skew, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule